// File: doc/BRIEF.md
# Programmable Display Sync Counter Bank

This block holds a bank of chained event counters. Firmware programs them through a simple write port, and together they produce the timing waveforms of a raster display: line sync, frame sync, line-active windows and pixel-active strobes. Each counter takes its events from a programmable source. That source is either the pixel-clock event or the pulse of another counter, so a line counter can drive a frame counter, and a line pulse can restart a pixel-window counter.

The block runs on a clock at twice the pixel rate. `pix_ph_i` marks the cycle that ends each pixel period, so one clock cycle is one half pixel period. Each counter drives a one-cycle pulse. It can also drive a level waveform whose rising and falling positions are set in half-pixel units after the pulse. When `en_i` is low, every counter is held idle with its outputs low. Raising `en_i` starts every counter whose clear source is zero.

Top module: `sync_cnt_bank`

## Requirements
- R1: After reset, and one cycle after any cycle with `en_i` low, every bit of `pulse_o` and `wave_o` is 0.
- R2: Source codes are 3 bits wide. Code 0 never fires. Code 1 is the pixel event, which is `en_i & pix_ph_i`. Code k+1 is the registered `pulse_o` of counter k, so only counters 1 to 6 can be selected.
- R3: In its run phase a counter pulses on every (run_count+1)-th event of its run source. The pulse is high in the cycle after that event.
- R4: When a counter is cleared, it counts offset_count events of its offset source before its run phase begins. An offset of 0 enters the run phase at once.
- R5: A repeat count of 0 makes the counter run forever. A nonzero repeat count N stops it after N pulses, until its clear source fires again.
- R6: Clear source 0 means the counter is armed on the first enabled cycle after a cycle with `en_i` low. A nonzero code arms it on that source's event. A clear takes priority over a simultaneous run or offset event and reloads every count.
- R7: With the waveform enable set, each pulse restarts a half-period timer at 0 in the next cycle. `wave_o` is high while the timer t satisfies up <= t < down. A down position of 0 keeps the wave low.
- R8: Word addresses (counter n = 1..8): control word 0 is at n-1, control word 1 is at 8+n-1, and the repeat word is at 16+(n-1)/2. Odd counters use bits [11:0] of the repeat word and even counters use bits [27:16]. Control word 0 holds run_count [30:19], run source [18:16], offset_count [14:3] and offset source [2:0]. Control word 1 holds waveform enable [29], clear source [27:25], down [24:16] and up [8:0]. Writes to addresses 20 to 31 have no effect.
- R9: A run count of 0 with a nonzero repeat count produces one pulse per run-source event, back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the pixel rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enable; low holds all counters idle |
| pix_ph_i | input | 1 | High on the cycle that ends a pixel period |
| we_i | input | 1 | Register write strobe |
| waddr_i | input | 5 | Register word address |
| wdata_i | input | 32 | Register write data |
| pulse_o | output | 8 | One-cycle pulse per counter |
| wave_o | output | 8 | Programmable level waveform per counter |

## Verification
A wrong remaining offset, run or repeat count does not show up at once. It appears at the next pulse that state governs, which can be a whole line or frame later, and the error then spreads through every counter sourced from it. A corrupted waveform timer shows on `wave_o` within down half-periods of the pulse that restarted it. For this reason the bench compares every output bit, every cycle, against a behavioural model, and also measures periods, burst lengths and pulse widths over line-length windows.

// File: rtl/sync_cnt_pkg.sv
package sync_cnt_pkg;
  localparam int CNT_W  = 12;
  localparam int SRC_W  = 3;
  localparam int EDGE_W = 9;

  typedef enum logic [1:0] {ST_IDLE, ST_OFFS, ST_RUN} cnt_st_e;

  typedef struct packed {
    logic [CNT_W-1:0]  run_cnt;
    logic [SRC_W-1:0]  run_src;
    logic [CNT_W-1:0]  off_cnt;
    logic [SRC_W-1:0]  off_src;
    logic [CNT_W-1:0]  rep_cnt;
    logic [SRC_W-1:0]  clr_src;
    logic              pol_en;
    logic [EDGE_W-1:0] up;
    logic [EDGE_W-1:0] dn;
  } cnt_cfg_t;
endpackage

// File: rtl/sync_cnt_cfg.sv
module sync_cnt_cfg
  import sync_cnt_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int ADDR_W  = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         waddr_i,
  input  logic [31:0]               wdata_i,
  output cnt_cfg_t [NUM_CNT-1:0]    cfg_o
);
  localparam int C1_BASE  = NUM_CNT;
  localparam int REP_BASE = 2 * NUM_CNT;

  logic unused_bits;
  assign unused_bits = ^{wdata_i[31:28], wdata_i[15:9]};

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cfg
    localparam int HB = (k % 2) * 16;
    localparam int RW = REP_BASE + k / 2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[k] <= '0;
      end else if (we_i) begin
        if (waddr_i == ADDR_W'(k)) begin
          cfg_o[k].run_cnt <= wdata_i[30:19];
          cfg_o[k].run_src <= wdata_i[18:16];
          cfg_o[k].off_cnt <= wdata_i[14:3];
          cfg_o[k].off_src <= wdata_i[2:0];
        end
        if (waddr_i == ADDR_W'(C1_BASE + k)) begin
          cfg_o[k].pol_en  <= wdata_i[29];
          cfg_o[k].clr_src <= wdata_i[27:25];
          cfg_o[k].dn      <= wdata_i[24:16];
          cfg_o[k].up      <= wdata_i[8:0];
        end
        if (waddr_i == ADDR_W'(RW)) begin
          cfg_o[k].rep_cnt <= wdata_i[HB +: CNT_W];
        end
      end
    end
  end
endmodule

// File: rtl/sync_cnt_unit.sv
module sync_cnt_unit
  import sync_cnt_pkg::*;
#(
  parameter int NUM_CNT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               start_i,
  input  logic               pix_i,
  input  logic [NUM_CNT-1:0] pulses_i,
  input  cnt_cfg_t           cfg_i,
  output logic               pulse_o
);
  cnt_st_e          st_q;
  logic [CNT_W-1:0] off_q, run_q, rep_q;
  logic             forever_q;
  logic             run_hit, off_hit, clr_hit;

  function automatic logic pick(input logic [SRC_W-1:0] code, input logic pix,
                                input logic [NUM_CNT-1:0] pv);
    logic r;
    r = (code == SRC_W'(1)) & pix;
    for (int j = 0; j < NUM_CNT; j++) begin
      if (int'(code) == j + 2) r = pv[j];
    end
    return r;
  endfunction

  assign run_hit = pick(cfg_i.run_src, pix_i, pulses_i);
  assign off_hit = pick(cfg_i.off_src, pix_i, pulses_i);
  assign clr_hit = (cfg_i.clr_src == '0) ? start_i : pick(cfg_i.clr_src, pix_i, pulses_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      off_q     <= '0;
      run_q     <= '0;
      rep_q     <= '0;
      forever_q <= 1'b0;
      pulse_o   <= 1'b0;
    end else if (!en_i) begin
      st_q    <= ST_IDLE;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (clr_hit) begin
        off_q     <= cfg_i.off_cnt;
        run_q     <= cfg_i.run_cnt;
        rep_q     <= cfg_i.rep_cnt;
        forever_q <= (cfg_i.rep_cnt == '0);
        st_q      <= (cfg_i.off_cnt == '0) ? ST_RUN : ST_OFFS;
      end else begin
        unique case (st_q)
          ST_OFFS: if (off_hit) begin
            if (off_q == CNT_W'(1)) st_q <= ST_RUN;
            off_q <= off_q - CNT_W'(1);
          end
          ST_RUN: if (run_hit) begin
            if (run_q == '0) begin
              pulse_o <= 1'b1;
              run_q   <= cfg_i.run_cnt;
              if (!forever_q) begin
                if (rep_q == CNT_W'(1)) st_q <= ST_IDLE;
                rep_q <= rep_q - CNT_W'(1);
              end
            end else begin
              run_q <= run_q - CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sync_wave_gen.sv
module sync_wave_gen
  import sync_cnt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              trig_i,
  input  logic              pol_en_i,
  input  logic [EDGE_W-1:0] up_i,
  input  logic [EDGE_W-1:0] dn_i,
  output logic              wave_o
);
  logic              act_q;
  logic [EDGE_W-1:0] t_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      t_q   <= '0;
    end else if (!en_i) begin
      act_q <= 1'b0;
      t_q   <= '0;
    end else if (trig_i && pol_en_i) begin
      act_q <= 1'b1;
      t_q   <= '0;
    end else if (act_q) begin
      if (t_q >= dn_i) act_q <= 1'b0;
      else             t_q   <= t_q + EDGE_W'(1);
    end
  end

  assign wave_o = act_q && (t_q >= up_i) && (t_q < dn_i);
endmodule

// File: rtl/sync_cnt_bank.sv
module sync_cnt_bank
  import sync_cnt_pkg::*;
#(
  parameter  int NUM_CNT = 8,
  localparam int ADDR_W  = $clog2(2 * NUM_CNT + (NUM_CNT + 1) / 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               pix_ph_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  waddr_i,
  input  logic [31:0]        wdata_i,
  output logic [NUM_CNT-1:0] pulse_o,
  output logic [NUM_CNT-1:0] wave_o
);
  cnt_cfg_t [NUM_CNT-1:0] cfg;
  logic [NUM_CNT-1:0]     pulse_vec;
  logic [NUM_CNT-1:0]     dn_zero;
  logic                   en_q, start, pix_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  assign start   = en_i & ~en_q;
  assign pix_evt = en_i & pix_ph_i;

  sync_cnt_cfg #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i),
    .waddr_i(waddr_i), .wdata_i(wdata_i), .cfg_o(cfg)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_ch
    sync_cnt_unit #(.NUM_CNT(NUM_CNT)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .start_i(start),
      .pix_i(pix_evt), .pulses_i(pulse_vec), .cfg_i(cfg[k]),
      .pulse_o(pulse_vec[k])
    );
    sync_wave_gen u_wave (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .trig_i(pulse_vec[k]),
      .pol_en_i(cfg[k].pol_en), .up_i(cfg[k].up), .dn_i(cfg[k].dn),
      .wave_o(wave_o[k])
    );
    assign dn_zero[k] = (cfg[k].dn == '0);
  end

  assign pulse_o = pulse_vec;
endmodule

// File: rtl/sync_cnt_bank_chk.sv
module sync_cnt_bank_chk #(
  parameter int NUM_CNT = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic [NUM_CNT-1:0] pulse_o,
  input logic [NUM_CNT-1:0] wave_o,
  input logic [NUM_CNT-1:0] dn_zero_i
);
  assert_idle_when_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pulse_o == '0 && wave_o == '0));

  assert_pulse_needs_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o != '0) |-> $past(en_i));

  assert_start_clean_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> (pulse_o == '0));

  assert_wave_needs_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_o != '0) |-> $past(en_i));

  assert_no_wave_zero_dn_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_o & dn_zero_i) == '0);
endmodule

bind sync_cnt_bank sync_cnt_bank_chk #(.NUM_CNT(NUM_CNT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
  .pulse_o(pulse_o), .wave_o(wave_o), .dn_zero_i(dn_zero)
);

// File: tb/sync_cnt_bank_tb.sv
module sync_cnt_bank_tb;
  localparam int N  = 8;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic          ph = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] waddr = '0;
  logic [31:0]   wdata = '0;
  logic [N-1:0]  pulse_o, wave_o;

  int checks = 0, fails = 0, tot4 = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_st[N], m_off[N], m_run[N], m_rep[N], m_t[N];
  bit m_fe[N], m_pl[N], m_act[N], m_op[N], m_enq;
  int c_run[N], c_rs[N], c_off[N], c_os[N], c_rep[N], c_clr[N], c_pol[N], c_up[N], c_dn[N];

  sync_cnt_bank #(.NUM_CNT(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pix_ph_i(ph), .we_i(we),
    .waddr_i(waddr), .wdata_i(wdata), .pulse_o(pulse_o), .wave_o(wave_o)
  );

  always #5 clk = ~clk;

  always @(negedge clk) ph <= ~ph;

  function automatic bit sel(int code, bit pix);
    if (code == 1) return pix;
    if (code >= 2 && code - 2 < N) return m_op[code-2];
    return 1'b0;
  endfunction

  task automatic model_step();
    bit start, pix, runh, offh, clrh;
    start = en && !m_enq;
    pix   = en && ph;
    for (int k = 0; k < N; k++) m_op[k] = m_pl[k];
    for (int k = 0; k < N; k++) begin
      runh = sel(c_rs[k], pix);
      offh = sel(c_os[k], pix);
      clrh = (c_clr[k] == 0) ? start : sel(c_clr[k], pix);
      if (!en) begin
        m_st[k] = 0; m_pl[k] = 0;
      end else begin
        m_pl[k] = 0;
        if (clrh) begin
          m_off[k] = c_off[k]; m_run[k] = c_run[k]; m_rep[k] = c_rep[k];
          m_fe[k] = (c_rep[k] == 0); m_st[k] = (c_off[k] == 0) ? 2 : 1;
        end else if (m_st[k] == 1 && offh) begin
          if (m_off[k] == 1) m_st[k] = 2;
          m_off[k]--;
        end else if (m_st[k] == 2 && runh) begin
          if (m_run[k] == 0) begin
            m_pl[k] = 1; m_run[k] = c_run[k];
            if (!m_fe[k]) begin
              if (m_rep[k] == 1) m_st[k] = 0;
              m_rep[k]--;
            end
          end else m_run[k]--;
        end
      end
      if (!en) begin
        m_act[k] = 0; m_t[k] = 0;
      end else if (m_op[k] && c_pol[k] != 0) begin
        m_act[k] = 1; m_t[k] = 0;
      end else if (m_act[k]) begin
        if (m_t[k] >= c_dn[k]) m_act[k] = 0;
        else m_t[k]++;
      end
    end
    m_enq = en;
    if (we) begin
      int a, d;
      a = int'(waddr); d = int'(wdata);
      if (a < N) begin
        c_run[a] = (d >> 19) & 4095; c_rs[a] = (d >> 16) & 7;
        c_off[a] = (d >> 3) & 4095;  c_os[a] = d & 7;
      end else if (a < 2*N) begin
        c_pol[a-N] = (d >> 29) & 1; c_clr[a-N] = (d >> 25) & 7;
        c_dn[a-N]  = (d >> 16) & 511; c_up[a-N] = d & 511;
      end else if (a < 2*N + N/2) begin
        c_rep[(a-2*N)*2]   = d & 4095;
        c_rep[(a-2*N)*2+1] = (d >> 16) & 4095;
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin
        m_st[k] = 0; m_off[k] = 0; m_run[k] = 0; m_rep[k] = 0; m_t[k] = 0;
        m_fe[k] = 0; m_pl[k] = 0; m_act[k] = 0; m_op[k] = 0;
        c_run[k] = 0; c_rs[k] = 0; c_off[k] = 0; c_os[k] = 0; c_rep[k] = 0;
        c_clr[k] = 0; c_pol[k] = 0; c_up[k] = 0; c_dn[k] = 0;
      end
      m_enq = 0;
    end else model_step();
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0] ep, ew;
      for (int k = 0; k < N; k++) begin
        ep[k] = m_pl[k];
        ew[k] = m_act[k] && m_t[k] >= c_up[k] && m_t[k] < c_dn[k];
      end
      chk({cur_req, " pulse vector"}, int'(pulse_o), int'(ep));
      chk({cur_req, " wave vector"}, int'(wave_o), int'(ew));
      if (pulse_o[3]) tot4++;
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = AW'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  function automatic logic [31:0] w0(int run, int rs, int off, int os);
    return (32'(run) << 19) | (32'(rs) << 16) | (32'(off) << 3) | 32'(os);
  endfunction

  function automatic logic [31:0] w1(int pol, int clr, int dn, int up);
    return (32'(pol) << 29) | (32'(clr) << 25) | (32'(dn) << 16) | 32'(up);
  endfunction

  task automatic wait_pulse(int k);
    do @(negedge clk); while (!pulse_o[k]);
  endtask

  task automatic count_win(int k, bit wv, int ncyc, output int cnt);
    cnt = 0;
    repeat (ncyc) begin
      if (wv ? wave_o[k] : pulse_o[k]) cnt++;
      @(negedge clk);
    end
  endtask

  task automatic period(int k, output int n);
    wait_pulse(k);
    n = 0;
    do begin @(negedge clk); n++; end while (!pulse_o[k]);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1ms;
    fails++; checks++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    chk("R1 reset outputs", int'({pulse_o, wave_o}), 0);
    rst_n = 1'b1;
    cur_req = "R8";
    // counter 1: line, 10 pixels, wave 2 pixels
    wr(0, w0(9, 1, 0, 0));    wr(8,  w1(1, 0, 4, 0));
    // counter 2: frame of 3 lines, sourced by counter 1
    wr(1, w0(2, 2, 0, 0));    wr(9,  w1(1, 0, 6, 2));
    // counter 3: 5 back-to-back pixels after 3, cleared by lines
    wr(2, w0(0, 1, 3, 1));    wr(10, w1(0, 2, 0, 0));
    // counter 4: offset of 2 lines, 3 pulses total
    wr(3, w0(1, 1, 2, 2));    wr(11, w1(0, 0, 0, 0));
    wr(17, (32'd3 << 16) | 32'd5);
    // counter 5: cleared by counter 3 pulses, one pulse
    wr(4, w0(3, 1, 0, 0));    wr(12, w1(0, 4, 0, 0));
    wr(18, 32'd1);
    tot4 = 0;
    @(negedge clk); en = 1'b1; cur_req = "R3";
    repeat (100) @(negedge clk);
    period(0, n);                chk("R3 line period", n, 20);
    wait_pulse(0);
    count_win(2, 0, 20, n);      chk("R9 pixel burst per line", n, 5);
    wait_pulse(0);
    count_win(0, 1, 20, n);      chk("R7 wave width", n, 4);
    wait_pulse(0);
    repeat (10) @(negedge clk);
    count_win(4, 0, 20, n);      chk("R6 clear priority single pulse", n, 1);
    period(1, n);                chk("R2 counter-sourced period", n, 60);
    chk("R5 repeat stops after 3", tot4, 3);
    chk("R4 offset count total", tot4, 3);
    cur_req = "R1";
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk("R1 idle when disabled", int'({pulse_o, wave_o}), 0);
    cur_req = "R8";
    wr(25, 32'hFFFF_FFFF);
    wr(0, w0(5, 1, 0, 0));
    wr(10, w1(0, 0, 0, 0));
    wr(17, (32'd3 << 16) | 32'd0);
    wr(5, w0(0, 1, 0, 0));    wr(13, w1(1, 0, 9, 1));
    wr(18, 32'd1);
    wr(6, w0(1, 7, 0, 0));
    tot4 = 0;
    @(negedge clk); en = 1'b1; cur_req = "R5";
    repeat (60) @(negedge clk);
    period(0, n);                chk("R8 unmapped write ignored, new period", n, 12);
    count_win(2, 0, 40, n);      chk("R5 forever with zero repeat", n, 20);
    count_win(5, 1, 20, n);      chk("R7 retrigger restarts timer", n, 10);
    count_win(6, 0, 40, n);      chk("R2 code 7 selects counter 6", n, 10);
    chk("R8 high half repeat", tot4, 3);
    cur_req = "R1";
    @(negedge clk); en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 idle after second disable", int'({pulse_o, wave_o}), 0);
    finish_run();
  end
endmodule